// File: doc/BRIEF.md
# Thermometer-Code Time Stamp Combiner

This block turns two sub-cycle snapshots into one timestamp. A bank of latches outside the block samples an event at the successive phases of a ring oscillator. A second bank samples the reference clock on the same phases. Both snapshots arrive as registered vectors. They come with a request line that rises once per event.

The block passes the request and both snapshots through a chain of synchronizing flops. It captures them together with its own coarse counter, which runs on the reference clock. It then finds the edge position in each snapshot and corrects the coarse count for events that fall just before a counter increment. It presents a coarse-plus-fine timestamp with a one-cycle valid strobe.

The fine part counts the phase steps from the reference edge to the event. An event whose phase is earlier than the reference edge belongs to the previous coarse period. That period is charged so the result is never one coarse period too high.

Top module: `tdc_stamp_combiner`

## Requirements
- R1: While and directly after reset, `valid_o`, `err_o` and `stamp_o` are 0 and the coarse counter restarts from 0.
- R2: The coarse counter adds one on every clock and wraps modulo 2^COARSE_W, so stamps near a wrap carry the wrapped count.
- R3: A snapshot is decoded to the lowest tap index i such that bit i and bit i+1 are both 1, with the bit above the top tap taken as 1. An isolated 1 below the edge (a bubble) does not move the result.
- R4: `stamp_o` is {coarse, fine}: the fine field is the low FINE_W bits and equals (event position − reference position) modulo TAPS, always in 0..TAPS−1.
- R5: `req_i` and both snapshots pass through SYNC_STAGES flops. For a request first sampled at edge k, `valid_o` is high after edge k+SYNC_STAGES+2. The captured coarse count is the counter value before edge k plus SYNC_STAGES. The snapshots must be held for SYNC_STAGES+1 cycles.
- R6: When the event position is lower than the reference position, the coarse field is the captured count minus one, modulo 2^COARSE_W.
- R7: If either snapshot has no run of two ones, `err_o` is 1 with the valid strobe. The stamp then carries the uncorrected captured count and a fine field of 0.
- R8: `valid_o` is a single-cycle pulse, one per accepted event.
- R9: A synchronized rising edge of the request that arrives while a previous result is still in flight is dropped and yields no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; clocks the coarse counter and all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Event request; a rising edge starts a capture |
| ev_snap_i | input | TAPS | Phase snapshot of the event, thermometer coded |
| ref_snap_i | input | TAPS | Phase snapshot of the reference clock, same phases |
| stamp_o | output | COARSE_W+FINE_W | Combined timestamp {coarse, fine} |
| err_o | output | 1 | Decode failure on either snapshot, qualified by valid_o |
| valid_o | output | 1 | One-cycle strobe for stamp_o and err_o |

## Verification
The bench builds the block with TAPS = 41 and SYNC_STAGES = 2. It narrows COARSE_W to 8 so that the coarse counter wraps many times within the run. One event is timed so that its captured count is exactly 0 while its event phase lies before the reference phase, which drives the decrement through the wrap. The positions 0 and 40 at both ends of the tap range, single-bit bubbles and empty snapshots are all within reach at that width.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
    // Bits needed to hold a tap index 0..taps-1.
    function automatic int index_bits(input int taps);
        return (taps > 1) ? $clog2(taps) : 1;
    endfunction
endpackage

// File: rtl/tdc_sync_chain.sv
`timescale 1ns/1ps
module tdc_sync_chain #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tdc_therm_decode.sv
`timescale 1ns/1ps
module tdc_therm_decode #(
    parameter int TAPS  = 41,
    parameter int POS_W = 6
) (
    input  logic [TAPS-1:0]  snap_i,
    output logic [POS_W-1:0] pos_o,
    output logic             found_o
);
    logic [TAPS:0] ext;

    always_comb begin
        ext     = {1'b1, snap_i};
        pos_o   = '0;
        found_o = 1'b0;
        // Scan downwards so the lowest qualifying run wins.
        for (int i = TAPS - 1; i >= 0; i--) begin
            if (ext[i] && ext[i+1]) begin
                pos_o   = POS_W'(i);
                found_o = 1'b1;
            end
        end
    end

    always_comb begin
        if (found_o) begin
            p_run_start_r3: assert (snap_i[pos_o] == 1'b1)
                else $error("decoded position does not hold a one");
        end
    end
endmodule

// File: rtl/tdc_stamp_combiner.sv
`timescale 1ns/1ps
module tdc_stamp_combiner #(
    parameter int TAPS        = 41,
    parameter int COARSE_W    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FINE_W      = tdc_pkg::index_bits(TAPS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_i,
    input  logic [TAPS-1:0]            ev_snap_i,
    input  logic [TAPS-1:0]            ref_snap_i,
    output logic [COARSE_W+FINE_W-1:0] stamp_o,
    output logic                       err_o,
    output logic                       valid_o
);
    localparam int SYNC_W  = 2 * TAPS + 1;
    localparam int STAMP_W = COARSE_W + FINE_W;

    typedef struct packed {
        logic                req_prev;
        logic                busy;
        logic [COARSE_W-1:0] coarse;
        logic                v1;
        logic [TAPS-1:0]     cap_ev;
        logic [TAPS-1:0]     cap_ref;
        logic [COARSE_W-1:0] cap_coarse;
        logic                v2;
        logic [FINE_W-1:0]   ev_pos;
        logic [FINE_W-1:0]   ref_pos;
        logic                bad;
        logic [COARSE_W-1:0] dec_coarse;
        logic [STAMP_W-1:0]  stamp;
        logic                err;
        logic                valid;
    } state_t;

    state_t state_d, state_q;

    // Synchronizer for request and both snapshots.
    logic [SYNC_W-1:0] sync_out;
    logic              sync_req;
    logic [TAPS-1:0]   sync_ev, sync_ref;

    tdc_sync_chain #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({req_i, ev_snap_i, ref_snap_i}),
        .q_o   (sync_out)
    );
    assign {sync_req, sync_ev, sync_ref} = sync_out;

    // One decoder per captured snapshot.
    logic [TAPS-1:0]   dec_in    [2];
    logic [FINE_W-1:0] dec_pos   [2];
    logic              dec_found [2];

    assign dec_in[0] = state_q.cap_ev;
    assign dec_in[1] = state_q.cap_ref;

    for (genvar g = 0; g < 2; g++) begin : g_dec
        tdc_therm_decode #(.TAPS(TAPS), .POS_W(FINE_W)) u_dec (
            .snap_i  (dec_in[g]),
            .pos_o   (dec_pos[g]),
            .found_o (dec_found[g])
        );
    end

    logic                rise, take;
    logic [FINE_W:0]     fine_sum;
    logic [COARSE_W-1:0] coarse_out;

    always_comb begin
        state_d    = state_q;
        fine_sum   = '0;
        coarse_out = state_q.dec_coarse;

        rise = sync_req & ~state_q.req_prev;
        take = rise & ~state_q.busy;

        state_d.req_prev = sync_req;
        state_d.coarse   = state_q.coarse + 1'b1;

        // Stage 1: capture.
        state_d.v1 = take;
        if (take) begin
            state_d.cap_ev     = sync_ev;
            state_d.cap_ref    = sync_ref;
            state_d.cap_coarse = state_q.coarse;
        end

        // Stage 2: decode.
        state_d.v2 = state_q.v1;
        if (state_q.v1) begin
            state_d.ev_pos     = dec_pos[0];
            state_d.ref_pos    = dec_pos[1];
            state_d.bad        = ~(dec_found[0] & dec_found[1]);
            state_d.dec_coarse = state_q.cap_coarse;
        end

        // Stage 3: combine.
        state_d.valid = state_q.v2;
        if (state_q.v2) begin
            if (state_q.bad) begin
                state_d.stamp = {state_q.dec_coarse, {FINE_W{1'b0}}};
                state_d.err   = 1'b1;
            end else begin
                if (state_q.ev_pos < state_q.ref_pos) begin
                    fine_sum   = {1'b0, state_q.ev_pos} + (FINE_W+1)'(TAPS)
                               - {1'b0, state_q.ref_pos};
                    coarse_out = state_q.dec_coarse - 1'b1;
                end else begin
                    fine_sum   = {1'b0, state_q.ev_pos} - {1'b0, state_q.ref_pos};
                    coarse_out = state_q.dec_coarse;
                end
                state_d.stamp = {coarse_out, fine_sum[FINE_W-1:0]};
                state_d.err   = 1'b0;
            end
        end

        if (take)            state_d.busy = 1'b1;
        else if (state_q.v2) state_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign stamp_o = state_q.stamp;
    assign err_o   = state_q.err;
    assign valid_o = state_q.valid;

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> state_q.coarse == $past(state_q.coarse) + 1'b1)
        else $error("coarse counter did not step");

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ##3 valid_o)
        else $error("result did not appear three edges after capture");

    p_fine_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !err_o) |-> (stamp_o[FINE_W-1:0] < FINE_W'(TAPS)))
        else $error("fine field out of range");

    p_err_fine_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && err_o) |-> (stamp_o[FINE_W-1:0] == '0))
        else $error("error result carries a fine value");

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o)
        else $error("valid held longer than one cycle");

    p_inflight_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(state_q.busy))
        else $error("result without an event in flight");
endmodule

// File: tb/tdc_stamp_combiner_tb.sv
`timescale 1ns/1ps
module tdc_stamp_combiner_tb;
    localparam int TAPS = 41;
    localparam int CW   = 8;
    localparam int FW   = 6;
    localparam int SYNC = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic [TAPS-1:0]  evs = '0, refs = '0;
    logic [CW+FW-1:0] stamp;
    logic             err, valid;

    int  n_cmp = 0, n_bad = 0, cnt = 0;
    bit  done = 1'b0;

    typedef struct { int cyc; int ts; bit er; string tag; } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    tdc_stamp_combiner #(.TAPS(TAPS), .COARSE_W(CW), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ev_snap_i(evs), .ref_snap_i(refs),
        .stamp_o(stamp), .err_o(err), .valid_o(valid));

    always @(posedge clk) if (rst_n) cnt <= cnt + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cnt);
        end
    endtask

    // Per-cycle comparison against the expected-result queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (expq.size() > 0 && expq[0].cyc == cnt) begin
                check(valid == 1'b1, {expq[0].tag, " valid"}, int'(valid), 1);
                check(int'(stamp) == expq[0].ts, {expq[0].tag, " stamp"}, int'(stamp), expq[0].ts);
                check(err == expq[0].er, {expq[0].tag, " err"}, int'(err), int'(expq[0].er));
                void'(expq.pop_front());
            end else begin
                check(valid == 1'b0, "R8/R9 no stray valid", int'(valid), 0);
            end
        end
    end

    function automatic logic [TAPS-1:0] therm(input int p, input bit bub);
        logic [TAPS-1:0] s;
        for (int i = 0; i < TAPS; i++) s[i] = (i >= p);
        if (bub && p >= 2) s[$urandom_range(p - 2, 0)] = 1'b1;
        return s;
    endfunction

    // Called just after a negedge. Drives one event and queues its result.
    task automatic send(input logic [TAPS-1:0] es, input logic [TAPS-1:0] rs,
                        input int ep, input int rp, input bit er, input string tag);
        exp_t e;
        int   n, co, fi;
        n = cnt;
        evs = es; refs = rs; req = 1'b1;
        co = n + SYNC;
        fi = 0;
        if (!er) begin
            if (ep < rp) co = co - 1;
            fi = (ep - rp + TAPS) % TAPS;
        end
        co = ((co % (1 << CW)) + (1 << CW)) % (1 << CW);
        e.cyc = n + SYNC + 3; e.ts = co * (1 << FW) + fi; e.er = er; e.tag = tag;
        expq.push_back(e);
        @(negedge clk); req = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_pos(input int ep, input int rp, input bit bub, input string tag);
        send(therm(ep, bub), therm(rp, bub), ep, rp, 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid == 1'b0 && err == 1'b0, "R1 reset flags", int'(valid) + int'(err), 0);
        check(stamp == '0, "R1 reset stamp", int'(stamp), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(stamp == '0 && valid == 1'b0, "R1 after release", int'(stamp), 0);

        send_pos(10, 3, 1'b0, "R4 event after reference");
        send_pos(3, 10, 1'b0, "R6 event before reference");
        send_pos(17, 17, 1'b0, "R4 equal phases");
        send_pos(40, 0, 1'b0, "R4 top tap");
        send_pos(0, 40, 1'b0, "R6 bottom tap");
        send_pos(30, 5, 1'b1, "R3 bubbles below edge");
        send_pos(6, 25, 1'b1, "R3 bubbles with decrement");
        send('0, therm(4, 1'b0), 0, 4, 1'b1, "R7 empty event snapshot");
        send(therm(9, 1'b0), '0, 9, 0, 1'b1, "R7 empty reference snapshot");
        send({1'b0, 40'h55_5555_5555}, therm(2, 1'b0), 0, 2, 1'b1, "R7 only isolated ones");
        send_pos(12, 8, 1'b0, "R5 latency and capture");

        // R9: a second request edge while the first result is in flight.
        begin
            exp_t e;
            int n;
            n = cnt;
            evs = therm(20, 1'b0); refs = therm(11, 1'b0); req = 1'b1;
            e.cyc = n + SYNC + 3; e.ts = ((n + SYNC) % (1 << CW)) * (1 << FW) + 9;
            e.er = 1'b0; e.tag = "R9 first of close pair";
            expq.push_back(e);
            @(negedge clk); req = 1'b0;
            @(negedge clk); req = 1'b1;
            @(negedge clk); req = 1'b0;
            repeat (8) @(negedge clk);
        end

        // R2 and R6: captured count exactly at the wrap, with decrement.
        while (((cnt + SYNC) % (1 << CW)) != 0) @(negedge clk);
        send_pos(2, 30, 1'b0, "R2 R6 decrement across wrap");
        while (((cnt + SYNC) % (1 << CW)) != 0) @(negedge clk);
        send_pos(30, 2, 1'b0, "R2 wrap without decrement");

        for (int k = 0; k < 300; k++) begin
            int ep, rp;
            ep = $urandom_range(TAPS - 1, 0);
            rp = $urandom_range(TAPS - 1, 0);
            send_pos(ep, rp, k[0], "R4 R6 random event");
        end

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R8 all results seen", expq.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule